// File: doc/BRIEF.md
# FMCW Multi-Segment Ramp Sequencer

This block generates the fractional-numerator offset that a synthesizer's delta-sigma modulator adds to its feedback divide value, so that the output frequency follows a piecewise-linear sweep. The clock is the phase detector clock, and the sequencer takes one step per clock. Up to eight segments are held as configuration. Each segment carries the following:
- a signed 30-bit increment that is added to the offset on every cycle of the segment
- a 16-bit length, and a doubling bit that makes each count of the length last two cycles
- a pointer to the segment that follows
- a selector that chooses whether the sequencer moves on when the segment ends or waits for one of three external triggers
- a fastlock bit and two flag bits that are presented while the segment is active

A start strobe restarts the sweep at segment 0 with a zero offset. The host raises the strobe whenever the low byte of the divide value is written with the enable set. The offset is a 33-bit two's-complement value. It is clamped to a programmable low limit and high limit. Two threshold comparators signal when the sweep has crossed a level in its current direction. A repeat count can end the sweep after a set number of passes through the pattern. A pass counts as complete each time the sequencer advances into segment 0.

The controller is a four-state machine:
- **IDLE**: the enable is low, or no start has been seen.
- **RUN**: a segment is stepping.
- **WAIT**: a segment has ended and the sequencer is waiting for its trigger.
- **DONE**: the repeat count is used up.

The transitions are:
- *go*: any state to RUN, on the start strobe with the enable high.
- *seg_end_auto*: RUN to RUN on the next segment.
- *seg_end_wait*: RUN to WAIT.
- *trig_hit*: WAIT to RUN.
- *pattern_end*: RUN or WAIT to DONE.
- *stop*: any state to IDLE when the enable is low.

While the machine is out of IDLE, `busy` is high. The modulator uses `busy` to force its denominator to 2^24.

Top module: `fmcw_ramp_seq`

## Requirements
- R1: With `enable` high, a `start` pulse sampled at a clock edge puts the block in RUN with `seg_idx` = 0 and `num_offset` = 0 after that edge, from any state.
- R2: On each clock edge in RUN, the active segment's 30-bit increment is sign-extended and added to `num_offset`.
- R3: A segment with doubling bit 0 lasts `len` RUN cycles. With doubling bit 1 it lasts 2×`len` RUN cycles. A length of 0 behaves as one cycle.
- R4: The 2-bit advance selector of a segment (`seg_advsel`, two bits per segment) chooses how the segment is left: 0 advances to `seg_next` on completion, while 1, 2 and 3 enter WAIT for a rising edge of `trig_a`, `trig_b` or `trig_c` respectively. A rising edge on a trigger that is not selected has no effect.
- R5: In WAIT, `num_offset` and `seg_idx` are held. Trigger rising edges that occur outside WAIT are ignored; a trigger that was already high on entry to WAIT must fall and rise again.
- R6: Each advance into segment 0 completes a pass. With `repeat_cnt` = N ≠ 0, the advance that completes pass N enters DONE instead. DONE sets `done` and holds `num_offset` and `seg_idx`. With `repeat_cnt` = 0 the pattern repeats without end.
- R7: `num_offset` never steps above `lim_hi` or below `lim_lo` (33-bit signed). A step that would pass a limit leaves the offset at that limit.
- R8: A comparator output is 1 only when the block is busy, its mask bit for the active segment is set, and one of two cases holds: the active increment is non-negative (rising) and the offset is above the threshold, or the increment is negative (falling) and the offset is below the threshold. In every other case the output is 0.
- R9: While `enable` is low, the block is IDLE after each edge. In IDLE, `busy` = 0, `done` = 0, `num_offset` = 0 and `seg_idx` = 0, and `start` is ignored.
- R10: `fastlock` and `seg_flags` show the active segment's fastlock bit and flag bits in RUN and WAIT, and are 0 in IDLE and DONE.
- R11: After reset, the block is IDLE with every output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase detector clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Ramp mode enable |
| start | input | 1 | Restart strobe (low divide byte written) |
| trig_a | input | 1 | External trigger A |
| trig_b | input | 1 | External trigger B |
| trig_c | input | 1 | External trigger C |
| repeat_cnt | input | 13 | Pattern passes before stopping; 0 = endless |
| seg_inc | input | 240 | Per-segment signed increment, 30 bits each, segment i at [30i +: 30] |
| seg_len | input | 128 | Per-segment length, 16 bits each |
| seg_dly | input | 8 | Per-segment length-doubling bit |
| seg_next | input | 24 | Per-segment next pointer, 3 bits each |
| seg_advsel | input | 16 | Per-segment advance selector, 2 bits each |
| seg_fl | input | 8 | Per-segment fastlock bit |
| seg_flag | input | 16 | Per-segment flag bits, 2 bits each |
| cmp0_mask | input | 8 | Comparator 0 per-segment enable |
| cmp1_mask | input | 8 | Comparator 1 per-segment enable |
| cmp0_thr | input | 33 | Comparator 0 threshold, signed |
| cmp1_thr | input | 33 | Comparator 1 threshold, signed |
| lim_lo | input | 33 | Lower offset limit, signed |
| lim_hi | input | 33 | Upper offset limit, signed |
| num_offset | output | 33 | Fractional numerator offset, signed |
| seg_idx | output | 3 | Active segment |
| busy | output | 1 | Ramp engaged (denominator forced to 2^24) |
| fastlock | output | 1 | Fastlock request of active segment |
| seg_flags | output | 2 | Flag bits of active segment |
| cmp0_hit | output | 1 | Comparator 0 crossing flag |
| cmp1_hit | output | 1 | Comparator 1 crossing flag |
| done | output | 1 | Repeat count exhausted |

## Verification
The bench builds the block with its default parameters: eight segments, 16-bit lengths, 30-bit increments, a 33-bit offset and a 13-bit repeat count. The 33-bit offset lets a maximal 30-bit increment drive the sweep into both default limits, ±2^32, within twenty cycles, so saturation at both limits is exercised. The 3-bit segment index covers multi-segment chains, including a jump that skips a segment. The repeat counter covers both bounded and endless patterns.

// File: rtl/fmcw_ramp_pkg.sv
package fmcw_ramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } ramp_state_e;

    // advance selector encodings
    localparam logic [1:0] ADV_AUTO = 2'd0;
    localparam logic [1:0] ADV_TRGA = 2'd1;
    localparam logic [1:0] ADV_TRGB = 2'd2;
    localparam logic [1:0] ADV_TRGC = 2'd3;

endpackage

// File: rtl/fmcw_ramp_step.sv
// One accumulation step: adds a sign-extended increment and saturates.
module fmcw_ramp_step #(
    parameter int INC_W = 30,
    parameter int ACC_W = 33
) (
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [INC_W-1:0] inc,
    input  logic [ACC_W-1:0] lim_lo,
    input  logic [ACC_W-1:0] lim_hi,
    output logic [ACC_W-1:0] acc_nxt
);
    localparam int EXT_W = ACC_W + 1;

    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] lo_x;
    logic signed [EXT_W-1:0] hi_x;

    assign sum  = $signed({acc_cur[ACC_W-1], acc_cur})
                + $signed({{(EXT_W-INC_W){inc[INC_W-1]}}, inc});
    assign lo_x = $signed({lim_lo[ACC_W-1], lim_lo});
    assign hi_x = $signed({lim_hi[ACC_W-1], lim_hi});

    always_comb begin
        if (sum > hi_x) begin
            acc_nxt = lim_hi;
        end else if (sum < lo_x) begin
            acc_nxt = lim_lo;
        end else begin
            acc_nxt = sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/fmcw_ramp_cmp.sv
// Direction-aware threshold crossing detector.
module fmcw_ramp_cmp #(
    parameter int ACC_W = 33
) (
    input  logic             active,
    input  logic             seg_en,
    input  logic             falling,
    input  logic [ACC_W-1:0] value,
    input  logic [ACC_W-1:0] thresh,
    output logic             hit
);
    logic above;
    logic below;

    assign above = $signed(value) > $signed(thresh);
    assign below = $signed(value) < $signed(thresh);
    assign hit   = active && seg_en && (falling ? below : above);
endmodule

// File: rtl/fmcw_ramp_seq.sv
module fmcw_ramp_seq
    import fmcw_ramp_pkg::*;
#(
    parameter int NSEG   = 8,
    parameter int LEN_W  = 16,
    parameter int INC_W  = 30,
    parameter int ACC_W  = 33,
    parameter int RPT_W  = 13,
    parameter int FLAG_W = 2,
    parameter int IDX_W  = $clog2(NSEG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    start,
    input  logic                    trig_a,
    input  logic                    trig_b,
    input  logic                    trig_c,
    input  logic [RPT_W-1:0]        repeat_cnt,
    input  logic [NSEG*INC_W-1:0]   seg_inc,
    input  logic [NSEG*LEN_W-1:0]   seg_len,
    input  logic [NSEG-1:0]         seg_dly,
    input  logic [NSEG*IDX_W-1:0]   seg_next,
    input  logic [NSEG*2-1:0]       seg_advsel,
    input  logic [NSEG-1:0]         seg_fl,
    input  logic [NSEG*FLAG_W-1:0]  seg_flag,
    input  logic [NSEG-1:0]         cmp0_mask,
    input  logic [NSEG-1:0]         cmp1_mask,
    input  logic [ACC_W-1:0]        cmp0_thr,
    input  logic [ACC_W-1:0]        cmp1_thr,
    input  logic [ACC_W-1:0]        lim_lo,
    input  logic [ACC_W-1:0]        lim_hi,
    output logic [ACC_W-1:0]        num_offset,
    output logic [IDX_W-1:0]        seg_idx,
    output logic                    busy,
    output logic                    fastlock,
    output logic [FLAG_W-1:0]       seg_flags,
    output logic                    cmp0_hit,
    output logic                    cmp1_hit,
    output logic                    done
);
    localparam int DUR_W  = LEN_W + 1;
    localparam int NCMP   = 2;

    ramp_state_e       state_q, state_d;
    logic [IDX_W-1:0]  seg_q, seg_d;
    logic [ACC_W-1:0]  acc_q, acc_d;
    logic [DUR_W-1:0]  cnt_q, cnt_d;
    logic [RPT_W-1:0]  pass_q, pass_d;
    logic [2:0]        trig_prev_q;

    // active segment fields
    logic [INC_W-1:0]  cur_inc;
    logic [LEN_W-1:0]  cur_len;
    logic [IDX_W-1:0]  cur_next;
    logic [1:0]        cur_adv;
    logic [FLAG_W-1:0] cur_flag;
    logic [DUR_W-1:0]  cur_dur;
    logic              seg_last;
    logic [ACC_W-1:0]  step_acc;
    logic [2:0]        trig_rise;
    logic              wake;
    logic              in_wait;
    logic              pass_end;
    logic              pattern_over;
    logic              do_adv;
    logic [NCMP-1:0]   hit;
    logic [ACC_W-1:0]  thr_sel  [NCMP];
    logic [NSEG-1:0]   mask_sel [NCMP];

    assign cur_inc  = seg_inc[int'(seg_q)*INC_W +: INC_W];
    assign cur_len  = seg_len[int'(seg_q)*LEN_W +: LEN_W];
    assign cur_next = seg_next[int'(seg_q)*IDX_W +: IDX_W];
    assign cur_adv  = seg_advsel[int'(seg_q)*2 +: 2];
    assign cur_flag = seg_flag[int'(seg_q)*FLAG_W +: FLAG_W];
    assign cur_dur  = seg_dly[seg_q] ? {cur_len, 1'b0} : {1'b0, cur_len};
    assign seg_last = (cur_dur == '0) || (cnt_q == cur_dur - DUR_W'(1));

    assign trig_rise = {trig_c, trig_b, trig_a} & ~trig_prev_q;
    assign in_wait   = (state_q == ST_WAIT);

    always_comb begin
        unique case (cur_adv)
            ADV_TRGA: wake = trig_rise[0];
            ADV_TRGB: wake = trig_rise[1];
            ADV_TRGC: wake = trig_rise[2];
            default:  wake = 1'b0;
        endcase
    end

    assign pass_end     = (cur_next == '0);
    assign pattern_over = pass_end && (repeat_cnt != '0)
                        && ((pass_q + 1'b1) == repeat_cnt);

    fmcw_ramp_step #(.INC_W(INC_W), .ACC_W(ACC_W)) u_step (
        .acc_cur (acc_q),
        .inc     (cur_inc),
        .lim_lo  (lim_lo),
        .lim_hi  (lim_hi),
        .acc_nxt (step_acc)
    );

    assign thr_sel[0]  = cmp0_thr;
    assign thr_sel[1]  = cmp1_thr;
    assign mask_sel[0] = cmp0_mask;
    assign mask_sel[1] = cmp1_mask;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        fmcw_ramp_cmp #(.ACC_W(ACC_W)) u_cmp (
            .active  (state_q != ST_IDLE),
            .seg_en  (mask_sel[g][seg_q]),
            .falling (cur_inc[INC_W-1]),
            .value   (acc_q),
            .thresh  (thr_sel[g]),
            .hit     (hit[g])
        );
    end

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        seg_d   = seg_q;
        acc_d   = acc_q;
        cnt_d   = cnt_q;
        pass_d  = pass_q;
        do_adv  = 1'b0;
        if (!enable) begin                      // stop
            state_d = ST_IDLE;
            seg_d   = '0;
            acc_d   = '0;
            cnt_d   = '0;
            pass_d  = '0;
        end else if (start) begin               // go
            state_d = ST_RUN;
            seg_d   = '0;
            acc_d   = '0;
            cnt_d   = '0;
            pass_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    acc_d = step_acc;
                    if (seg_last) begin
                        if (cur_adv == ADV_AUTO) begin
                            do_adv = 1'b1;      // seg_end_auto
                        end else begin
                            state_d = ST_WAIT;  // seg_end_wait
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WAIT: do_adv = wake;         // trig_hit
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
            if (do_adv) begin
                cnt_d = '0;
                if (pattern_over) begin
                    state_d = ST_DONE;          // pattern_end
                end else begin
                    state_d = ST_RUN;
                    seg_d   = cur_next;
                    if (pass_end) begin
                        pass_d = pass_q + 1'b1;
                    end
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            seg_q       <= '0;
            acc_q       <= '0;
            cnt_q       <= '0;
            pass_q      <= '0;
            trig_prev_q <= '0;
        end else begin
            state_q     <= state_d;
            seg_q       <= seg_d;
            acc_q       <= acc_d;
            cnt_q       <= cnt_d;
            pass_q      <= pass_d;
            trig_prev_q <= {trig_c, trig_b, trig_a};
        end
    end

    // outputs
    always_comb begin
        num_offset = acc_q;
        seg_idx    = seg_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        fastlock   = 1'b0;
        seg_flags  = '0;
        if (state_q == ST_RUN || state_q == ST_WAIT) begin
            fastlock  = seg_fl[seg_q];
            seg_flags = cur_flag;
        end
        cmp0_hit = hit[0];
        cmp1_hit = hit[1];
    end
endmodule

module fmcw_ramp_seq_chk #(
    parameter int ACC_W = 33,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             start,
    input logic             in_wait,
    input logic             wake,
    input logic [IDX_W-1:0] seg_idx,
    input logic [ACC_W-1:0] offset,
    input logic [ACC_W-1:0] lim_lo,
    input logic [ACC_W-1:0] lim_hi,
    input logic             busy,
    input logic             done,
    input logic             fastlock,
    input logic             cmp0_hit,
    input logic             cmp1_hit
);
    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start) |=> (busy && seg_idx == '0 && offset == '0));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !done && offset == '0 && seg_idx == '0));

    // R7
    limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $signed(lim_lo) <= $signed(lim_hi) && $stable(lim_lo) && $stable(lim_hi))
        |-> ($signed(offset) >= $signed(lim_lo) && $signed(offset) <= $signed(lim_hi)));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable && !start) |=> (done && $stable(offset) && $stable(seg_idx)));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && enable && !start && !wake) |=> (in_wait && $stable(offset) && $stable(seg_idx)));

    // R8
    cmp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmp0_hit && !cmp1_hit && !fastlock));
endmodule

bind fmcw_ramp_seq fmcw_ramp_seq_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start    (start),
    .in_wait  (in_wait),
    .wake     (wake),
    .seg_idx  (seg_idx),
    .offset   (num_offset),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .busy     (busy),
    .done     (done),
    .fastlock (fastlock),
    .cmp0_hit (cmp0_hit),
    .cmp1_hit (cmp1_hit)
);

// File: tb/fmcw_ramp_seq_test.sv
module fmcw_ramp_seq_test;
    localparam int NSEG = 8, LEN_W = 16, INC_W = 30, ACC_W = 33, RPT_W = 13;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0;
    logic trig_a = 1'b0, trig_b = 1'b0, trig_c = 1'b0;
    logic [RPT_W-1:0]      repeat_cnt;
    logic [NSEG*INC_W-1:0] seg_inc;
    logic [NSEG*LEN_W-1:0] seg_len;
    logic [NSEG-1:0]       seg_dly, seg_fl, cmp0_mask, cmp1_mask;
    logic [NSEG*3-1:0]     seg_next;
    logic [NSEG*2-1:0]     seg_advsel, seg_flag;
    logic [ACC_W-1:0]      cmp0_thr, cmp1_thr, lim_lo, lim_hi;
    logic [ACC_W-1:0]      num_offset;
    logic [2:0]            seg_idx;
    logic                  busy, fastlock, cmp0_hit, cmp1_hit, done;
    logic [1:0]            seg_flags;

    int total = 0, bad = 0, n;
    bit finished = 0;

    always #4 clk = ~clk;

    fmcw_ramp_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .trig_a(trig_a), .trig_b(trig_b), .trig_c(trig_c),
        .repeat_cnt(repeat_cnt), .seg_inc(seg_inc), .seg_len(seg_len),
        .seg_dly(seg_dly), .seg_next(seg_next), .seg_advsel(seg_advsel),
        .seg_fl(seg_fl), .seg_flag(seg_flag), .cmp0_mask(cmp0_mask),
        .cmp1_mask(cmp1_mask), .cmp0_thr(cmp0_thr), .cmp1_thr(cmp1_thr),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .num_offset(num_offset),
        .seg_idx(seg_idx), .busy(busy), .fastlock(fastlock),
        .seg_flags(seg_flags), .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit),
        .done(done)
    );

    typedef struct packed {
        logic [29:0] inc;
        logic [15:0] len;
        logic        dly;
        logic [15:0] dur;
        logic [32:0] expv;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{30'd5,          16'd10, 1'b0, 16'd10, 33'd50},
        '{30'h3FFFFFFD,   16'd7,  1'b1, 16'd14, 33'h1FFFFFFD6},
        '{30'd1000,       16'd1,  1'b0, 16'd1,  33'd1000},
        '{30'd0,          16'd0,  1'b0, 16'd1,  33'd0},
        '{30'h1FFFFFFF,   16'd20, 1'b0, 16'd20, 33'h0FFFFFFFF},
        '{30'h20000000,   16'd20, 1'b0, 16'd20, 33'h100000000}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint off();
        return longint'($signed(num_offset));
    endfunction

    task automatic clear_cfg();
        repeat_cnt = '0; seg_inc = '0; seg_len = '0; seg_dly = '0;
        seg_next = '0; seg_advsel = '0; seg_fl = '0; seg_flag = '0;
        cmp0_mask = '0; cmp1_mask = '0; cmp0_thr = '0; cmp1_thr = '0;
        lim_lo = 33'h100000000; lim_hi = 33'h0FFFFFFFF;
        trig_a = 0; trig_b = 0; trig_c = 0;
    endtask

    task automatic set_seg(input int i, input logic [29:0] inc, input logic [15:0] len,
                           input logic dly, input logic [2:0] nxt, input logic [1:0] adv,
                           input logic fl, input logic [1:0] flg);
        seg_inc[i*INC_W +: INC_W] = inc;
        seg_len[i*LEN_W +: LEN_W] = len;
        seg_dly[i] = dly;
        seg_next[i*3 +: 3] = nxt;
        seg_advsel[i*2 +: 2] = adv;
        seg_fl[i] = fl;
        seg_flag[i*2 +: 2] = flg;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic run_to_done();
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_cfg();
        enable = 1'b1;
        cycles(3);
        // R11 reset state
        chk("R11 offset", off(), 0);
        chk("R11 busy/done/seg", {busy, done, seg_idx, fastlock, cmp0_hit, cmp1_hit}, 0);
        @(negedge clk) rst_n = 1'b1;
        cycles(2);
        chk("R11 idle after release", {busy, done}, 0);

        // table: single segment, stop after one pass (R2 R3 R7)
        foreach (ROWS[r]) begin
            clear_cfg();
            set_seg(0, ROWS[r].inc, ROWS[r].len, ROWS[r].dly, 3'd0, 2'd0, 1'b0, 2'd0);
            repeat_cnt = 13'd1;
            pulse_start();
            run_to_done();
            chk($sformatf("R3 duration row%0d", r), n, ROWS[r].dur);
            chk($sformatf("R2 offset row%0d", r), off(), longint'($signed(ROWS[r].expv)));
        end

        // R4 R5 trigger chain
        clear_cfg();
        set_seg(0, 30'd2,   16'd3, 1'b0, 3'd1, 2'd0, 1'b0, 2'd0);
        set_seg(1, 30'd1,   16'd2, 1'b0, 3'd3, 2'd2, 1'b0, 2'd0);
        set_seg(3, 30'd100, 16'd1, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0);
        repeat_cnt = 13'd1;
        pulse_start();
        trig_b = 1'b1;               // edge while running: must be ignored
        cycles(5);
        chk("R4 wait seg", seg_idx, 1);
        chk("R4 wait offset", off(), 8);
        cycles(5);
        chk("R5 stale edge ignored seg", seg_idx, 1);
        chk("R5 held offset", off(), 8);
        @(negedge clk) trig_a = 1'b1;
        @(negedge clk) trig_a = 1'b0;
        cycles(1);
        chk("R4 unselected trigger", seg_idx, 1);
        @(negedge clk) trig_b = 1'b0;
        @(negedge clk) trig_b = 1'b1;
        cycles(1);
        chk("R4 trigger advances", seg_idx, 3);
        chk("R4 offset after wake", off(), 8);
        cycles(1);
        chk("R6 done after pass", done, 1);
        chk("R6 final offset", off(), 108);
        chk("R6 seg held", seg_idx, 3);

        // R6 bounded repeat
        clear_cfg();
        set_seg(0, 30'd4,         16'd2, 1'b0, 3'd1, 2'd0, 1'b0, 2'd0);
        set_seg(1, 30'h3FFFFFFF,  16'd3, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0);
        repeat_cnt = 13'd3;
        pulse_start();
        run_to_done();
        chk("R6 three passes cycles", n, 15);
        chk("R6 three passes offset", off(), 15);
        cycles(4);
        chk("R6 offset held in done", off(), 15);
        chk("R6 done held", done, 1);

        // R6 endless, R1 restart mid-run
        repeat_cnt = 13'd0;
        pulse_start();
        cycles(40);
        chk("R6 endless not done", done, 0);
        chk("R6 endless offset", off(), 40);
        chk("R6 endless seg", seg_idx, 0);
        cycles(3);
        pulse_start();
        chk("R1 restart offset", off(), 0);
        chk("R1 restart seg", seg_idx, 0);
        cycles(1);
        chk("R1 first step", off(), 4);

        // R9 enable low
        @(negedge clk) enable = 1'b0;
        cycles(1);
        chk("R9 idle", {busy, done}, 0);
        chk("R9 offset cleared", off(), 0);
        pulse_start();
        chk("R9 start ignored", busy, 0);
        enable = 1'b1;

        // R7 narrow limits
        clear_cfg();
        lim_hi = 33'd100;
        set_seg(0, 30'd30, 16'd10, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0);
        repeat_cnt = 13'd1;
        pulse_start();
        run_to_done();
        chk("R7 high clamp", off(), 100);
        lim_lo = 33'h1FFFFFFCE;      // -50
        set_seg(0, 30'h3FFFFFE2, 16'd10, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0);
        pulse_start();
        run_to_done();
        chk("R7 low clamp", off(), -50);

        // R8 comparators, R10 segment outputs
        clear_cfg();
        set_seg(0, 30'd10,        16'd10, 1'b0, 3'd1, 2'd0, 1'b1, 2'b01);
        set_seg(1, 30'h3FFFFFF6,  16'd10, 1'b0, 3'd0, 2'd0, 1'b0, 2'b10);
        repeat_cnt = 13'd1;
        cmp0_thr = 33'd45; cmp0_mask = 8'b0000_0001;
        cmp1_thr = 33'd25; cmp1_mask = 8'b0000_0011;
        pulse_start();
        cycles(4);
        chk("R8 cmp0 below thr rising", cmp0_hit, 0);
        chk("R8 cmp1 above thr rising", cmp1_hit, 1);
        chk("R10 fastlock seg0", fastlock, 1);
        chk("R10 flags seg0", seg_flags, 1);
        cycles(1);
        chk("R8 cmp0 crossed", cmp0_hit, 1);
        cycles(5);
        chk("R8 seg1 active", seg_idx, 1);
        chk("R8 cmp0 masked", cmp0_hit, 0);
        chk("R8 cmp1 falling above", cmp1_hit, 0);
        chk("R10 fastlock seg1", fastlock, 0);
        chk("R10 flags seg1", seg_flags, 2);
        cycles(8);
        chk("R8 cmp1 falling below", cmp1_hit, 1);
        run_to_done();
        chk("R10 outputs cleared in done", {fastlock, seg_flags}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule